// File: doc/BRIEF.md
# 3D Extremum Keypoint Detector

This block scans three aligned difference-of-Gaussian (DoG) pixel streams (a lower, a middle and an upper scale) that arrive together in raster order, one pixel of each plane per accepted cycle. For every pixel of the middle plane it decides whether that value is a strict local maximum or a strict local minimum of the 3×3×3 cube of samples centred on it. The cube spans the three scales. Each of these candidates is a raw keypoint. Later stages handle contrast and edge screening.

Each plane has its own store for the two previous image rows. The current row comes straight from the input. A sliding three-column window then collects all 27 samples. Two comparator trees work side by side: one tests the centre against all 26 neighbours for "greater", the other for "smaller", and their results are merged into the keypoint decision. A frame begins with a start-of-frame marker on its first pixel. The block then restarts its column and row counting. Results are reported only for centres that have a full neighbourhood inside the image, and they carry the coordinates of that centre.

Top module: `dog_extremum_detect`

## Requirements
- R1: While reset is high, and at the first sampling point after it, `kp_valid`, `kp_flag` and `kp_pol` are 0.
- R2: For each pixel accepted at column x, row y with x ≥ 2 and y ≥ 2, `kp_valid` is high for exactly one cycle. The pulse is registered on the third rising edge counting the edge that accepts the pixel. `kp_valid` is low in every other cycle.
- R3: A reported result carries `kp_x` = x−1 and `kp_y` = y−1, the window centre. Only centres with 1 ≤ x ≤ IMG_W−2 and 1 ≤ y ≤ IMG_H−2 are ever reported, so border pixels are never keypoints.
- R4: `kp_flag`=1 with `kp_pol`=1 when the middle-plane centre is strictly greater than all 26 neighbours in the three planes.
- R5: `kp_flag`=1 with `kp_pol`=0 when the centre is strictly smaller than all 26 neighbours.
- R6: A centre equal to any of its neighbours is not a keypoint (`kp_flag`=0), unless the other polarity holds strictly.
- R7: `kp_pol` is 0 whenever `kp_flag` is 0, and `kp_flag` is 0 whenever `kp_valid` is 0.
- R8: A pixel with `in_sof`=1 is taken as column 0, row 0, even in the middle of a frame. The first two rows of the new frame produce no result, so rows of an older frame are never combined with the new one.
- R9: Cycles with `in_valid`=0 have no effect on the stored rows, the window or the counters. Results and their latency relative to the accepting edge are the same as in a frame without gaps.
- R10: Samples are two's-complement signed values of DATA_W bits, and comparisons use signed order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel of all three planes is present |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_lo | input | DATA_W | Lower-scale DoG sample, signed |
| in_mid | input | DATA_W | Middle-scale DoG sample (centre plane), signed |
| in_hi | input | DATA_W | Upper-scale DoG sample, signed |
| kp_valid | output | 1 | A decision for one interior centre is present |
| kp_flag | output | 1 | The centre is a strict extremum |
| kp_pol | output | 1 | 1 = maximum, 0 = minimum; 0 when no keypoint |
| kp_x | output | $clog2(IMG_W) | Column of the centre pixel |
| kp_y | output | $clog2(IMG_H) | Row of the centre pixel |

## Verification
Each accepted pixel yields its decision three rising edges after it is accepted. The first edge loads the row-store reads, the second shifts the cube window and the third registers the comparator outcome. The bench computes the expected decision when it drives the pixel and passes it through its own three-stage delay line clocked on the same rising edges. It compares that against the outputs on the falling edge, so every check lands in the exact cycle the result is due, including frames with idle gaps. A border pixel or an idle slot therefore shows up as an unexpected or missing `kp_valid` pulse in that cycle, not as a reordering.

// File: rtl/dogx_pkg.sv
package dogx_pkg;
  // planes in the scale neighbourhood: lower, middle, upper
  localparam int PLANES = 3;
  // side of the square spatial window
  localparam int TAPS   = 3;
  // samples in the cube and position of its centre
  localparam int CUBE   = PLANES * TAPS * TAPS;
  localparam int CENTRE = CUBE / 2;
endpackage

// File: rtl/dog_row_store.sv
// Two-row history of one DoG plane. Both rows are RAMs with a registered,
// read-before-write port so that block RAM can be inferred.
module dog_row_store #(
  parameter int DATA_W = 8,
  parameter int IMG_W  = 320,
  localparam int AW    = $clog2(IMG_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] row_old,   // two rows above the incoming pixel
  output logic [DATA_W-1:0] row_prev,  // one row above
  output logic [DATA_W-1:0] row_now    // the incoming pixel, aligned
);
  logic [DATA_W-1:0] mem_near [IMG_W];
  logic [DATA_W-1:0] mem_far  [IMG_W];
  logic              en_d;
  logic [AW-1:0]     addr_d;

  // first row store: written with the input, read one row later
  always_ff @(posedge clk) begin
    if (en) begin
      mem_near[addr] <= din;
      row_prev       <= mem_near[addr];
    end
  end

  // second row store: written with what the first one gave back
  always_ff @(posedge clk) begin
    if (en_d) mem_far[addr_d] <= row_prev;
    if (en)   row_old <= mem_far[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d    <= 1'b0;
      addr_d  <= '0;
      row_now <= '0;
    end else begin
      en_d <= en;
      if (en) begin
        addr_d  <= addr;
        row_now <= din;
      end
    end
  end

  AST_ADDR_IN_ROW: assert property (@(posedge clk) disable iff (rst)
    en |-> (addr <= AW'(IMG_W - 1))) else $error("row store address out of range"); // R8
endmodule

// File: rtl/dog_cube_window.sv
// Three columns of three rows for each of the three planes.
// Index of a sample: plane*TAPS*TAPS + row*TAPS + column, column 0 oldest.
module dog_cube_window
  import dogx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 shift,
  input  logic [PLANES*TAPS-1:0][DATA_W-1:0]   col_in,
  output logic [CUBE-1:0][DATA_W-1:0]          cube
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cube <= '0;
    end else if (shift) begin
      for (int p = 0; p < PLANES; p++) begin
        for (int r = 0; r < TAPS; r++) begin
          for (int c = 0; c < TAPS - 1; c++) begin
            cube[p*TAPS*TAPS + r*TAPS + c] <= cube[p*TAPS*TAPS + r*TAPS + c + 1];
          end
          cube[p*TAPS*TAPS + r*TAPS + TAPS - 1] <= col_in[p*TAPS + r];
        end
      end
    end
  end
endmodule

// File: rtl/dog_extremum_cmp.sv
// Two parallel comparator trees: centre above every neighbour, and
// centre below every neighbour. Signed, strict.
module dog_extremum_cmp
  import dogx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [CUBE-1:0][DATA_W-1:0] cube,
  output logic                        is_max,
  output logic                        is_min
);
  localparam int NEIGH = CUBE - 1;

  logic signed [DATA_W-1:0] centre;
  logic [NEIGH-1:0]         above;
  logic [NEIGH-1:0]         below;

  assign centre = $signed(cube[CENTRE]);

  for (genvar k = 0; k < CUBE; k++) begin : g_nb
    if (k < CENTRE) begin : g_lo
      assign above[k] = centre > $signed(cube[k]);
      assign below[k] = centre < $signed(cube[k]);
    end else if (k > CENTRE) begin : g_hi
      assign above[k-1] = centre > $signed(cube[k]);
      assign below[k-1] = centre < $signed(cube[k]);
    end
  end

  assign is_max = &above;
  assign is_min = &below;
endmodule

// File: rtl/dog_extremum_detect.sv
module dog_extremum_detect
  import dogx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMG_W  = 320,
  parameter int IMG_H  = 240,
  localparam int XW    = $clog2(IMG_W),
  localparam int YW    = $clog2(IMG_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_lo,
  input  logic [DATA_W-1:0] in_mid,
  input  logic [DATA_W-1:0] in_hi,
  output logic              kp_valid,
  output logic              kp_flag,
  output logic              kp_pol,
  output logic [XW-1:0]     kp_x,
  output logic [YW-1:0]     kp_y
);
  // ---------------- raster position of the incoming pixel ----------------
  logic [XW-1:0] x_q, x_cur;
  logic [YW-1:0] y_q, y_cur;

  assign x_cur = in_sof ? '0 : x_q;
  assign y_cur = in_sof ? '0 : y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (in_valid) begin
      if (x_cur == XW'(IMG_W - 1)) begin
        x_q <= '0;
        y_q <= (y_cur == YW'(IMG_H - 1)) ? '0 : y_cur + 1'b1;
      end else begin
        x_q <= x_cur + 1'b1;
        y_q <= y_cur;
      end
    end
  end

  AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> (x_q == XW'(1) && y_q == '0)) else $error("sof did not restart"); // R8

  // ---------------- row stores, one per plane ----------------
  logic [PLANES-1:0][DATA_W-1:0]      plane_in;
  logic [PLANES*TAPS-1:0][DATA_W-1:0] col;

  assign plane_in = {in_hi, in_mid, in_lo};

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    dog_row_store #(.DATA_W(DATA_W), .IMG_W(IMG_W)) u_store (
      .clk      (clk),
      .rst      (rst),
      .en       (in_valid),
      .addr     (x_cur),
      .din      (plane_in[p]),
      .row_old  (col[p*TAPS + 0]),
      .row_prev (col[p*TAPS + 1]),
      .row_now  (col[p*TAPS + 2])
    );
  end

  // stage B: column of samples is ready; carry centre position along
  logic          vb, intb;
  logic [XW-1:0] xb;
  logic [YW-1:0] yb;

  always_ff @(posedge clk) begin
    if (rst) begin
      vb   <= 1'b0;
      intb <= 1'b0;
      xb   <= '0;
      yb   <= '0;
    end else begin
      vb <= in_valid;
      if (in_valid) begin
        intb <= (x_cur >= XW'(2)) && (y_cur >= YW'(2));
        xb   <= x_cur - 1'b1;
        yb   <= y_cur - 1'b1;
      end
    end
  end

  // ---------------- cube window ----------------
  logic [CUBE-1:0][DATA_W-1:0] cube;

  dog_cube_window #(.DATA_W(DATA_W)) u_window (
    .clk    (clk),
    .rst    (rst),
    .shift  (vb),
    .col_in (col),
    .cube   (cube)
  );

  // stage C: window complete
  logic          vc, intc;
  logic [XW-1:0] xc;
  logic [YW-1:0] yc;

  always_ff @(posedge clk) begin
    if (rst) begin
      vc   <= 1'b0;
      intc <= 1'b0;
      xc   <= '0;
      yc   <= '0;
    end else begin
      vc <= vb;
      if (vb) begin
        intc <= intb;
        xc   <= xb;
        yc   <= yb;
      end
    end
  end

  // ---------------- comparator trees ----------------
  logic is_max, is_min;

  dog_extremum_cmp #(.DATA_W(DATA_W)) u_cmp (
    .cube   (cube),
    .is_max (is_max),
    .is_min (is_min)
  );

  AST_ONE_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (vc && intc) |-> !(is_max && is_min)) else $error("both polarities"); // R4

  // ---------------- registered result ----------------
  logic report;
  assign report = vc && intc;

  always_ff @(posedge clk) begin
    if (rst) begin
      kp_valid <= 1'b0;
      kp_flag  <= 1'b0;
      kp_pol   <= 1'b0;
      kp_x     <= '0;
      kp_y     <= '0;
    end else begin
      kp_valid <= report;
      kp_flag  <= report && (is_max || is_min);
      kp_pol   <= report && is_max;
      if (report) begin
        kp_x <= xc;
        kp_y <= yc;
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    kp_valid |-> $past(in_valid, 3)) else $error("result without input"); // R2
  AST_INTERIOR_ONLY: assert property (@(posedge clk) disable iff (rst)
    kp_valid |-> (kp_x >= XW'(1) && kp_x <= XW'(IMG_W - 2) &&
                  kp_y >= YW'(1) && kp_y <= YW'(IMG_H - 2))) else $error("border reported"); // R3
  AST_POL_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    kp_pol |-> kp_flag) else $error("polarity without keypoint"); // R7
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    kp_flag |-> kp_valid) else $error("flag without valid"); // R7
endmodule

// File: tb/dog_extremum_detect_tb_top.sv
`timescale 1ns/1ps
module dog_extremum_detect_tb_top;
  localparam int DW = 8;
  localparam int W  = 8;
  localparam int H  = 6;
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic [DW-1:0] in_lo = '0, in_mid = '0, in_hi = '0;
  logic          kp_valid, kp_flag, kp_pol;
  logic [XW-1:0] kp_x;
  logic [YW-1:0] kp_y;

  always #2.5 clk = ~clk;

  dog_extremum_detect #(.DATA_W(DW), .IMG_W(W), .IMG_H(H)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_lo(in_lo), .in_mid(in_mid), .in_hi(in_hi),
    .kp_valid(kp_valid), .kp_flag(kp_flag), .kp_pol(kp_pol),
    .kp_x(kp_x), .kp_y(kp_y)
  );

  int checks = 0;
  int errors = 0;
  int fr [3][H][W];
  string phase_tag = "";
  bit chk_en = 0;

  // expectation for the pixel being driven, and its delay line
  bit    e0_v = 0, e0_f = 0, e0_p = 0;
  int    e0_x = 0, e0_y = 0;
  string e0_tag = "R2", e0_vtag = "R2";
  bit    pv [1:3], pf [1:3], pp [1:3];
  int    px [1:3], py [1:3];
  string pt [1:3], pvt [1:3];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= 3; i++) begin
        pv[i] <= 0; pf[i] <= 0; pp[i] <= 0; px[i] <= 0; py[i] <= 0;
        pt[i] <= "R2"; pvt[i] <= "R2";
      end
    end else begin
      pv[1] <= e0_v; pf[1] <= e0_f; pp[1] <= e0_p; px[1] <= e0_x; py[1] <= e0_y;
      pt[1] <= e0_tag; pvt[1] <= e0_vtag;
      for (int i = 2; i <= 3; i++) begin
        pv[i] <= pv[i-1]; pf[i] <= pf[i-1]; pp[i] <= pp[i-1];
        px[i] <= px[i-1]; py[i] <= py[i-1]; pt[i] <= pt[i-1]; pvt[i] <= pvt[i-1];
      end
    end
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // compare on the falling edge, three rising edges after acceptance
  always @(negedge clk) begin
    if (chk_en && !rst) begin
      chk(pvt[3], "kp_valid", int'(kp_valid), int'(pv[3]));
      if (pv[3] && kp_valid) begin
        chk("R3", "kp_x", int'(kp_x), px[3]);
        chk("R3", "kp_y", int'(kp_y), py[3]);
        chk(pt[3], "kp_flag", int'(kp_flag), int'(pf[3]));
        if (pf[3]) chk(pt[3], "kp_pol", int'(kp_pol), int'(pp[3]));
      end
      if (!pf[3]) chk("R7", "kp_pol idle", int'(kp_pol), 0);
    end
  end

  // reference: 0 none, 1 max, 2 min; tie set when any neighbour equals centre
  function automatic int ref_kind(input int cx, input int cy, output bit tie);
    int c = fr[1][cy][cx];
    bit gt = 1, lt = 1;
    tie = 0;
    for (int p = 0; p < 3; p++)
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++) begin
          int n;
          if (p == 1 && dy == 0 && dx == 0) continue;
          n = fr[p][cy+dy][cx+dx];
          if (!(c > n)) gt = 0;
          if (!(c < n)) lt = 0;
          if (c == n) tie = 1;
        end
    return gt ? 1 : (lt ? 2 : 0);
  endfunction

  task automatic push(input int x, input int y, input bit sof);
    @(negedge clk);
    in_valid = 1; in_sof = sof;
    in_lo  = DW'(fr[0][y][x]);
    in_mid = DW'(fr[1][y][x]);
    in_hi  = DW'(fr[2][y][x]);
    if (x >= 2 && y >= 2) begin
      bit tie;
      int k = ref_kind(x-1, y-1, tie);
      e0_v = 1; e0_f = (k != 0); e0_p = (k == 1);
      e0_x = x-1; e0_y = y-1;
      e0_vtag = (phase_tag != "") ? phase_tag : "R2";
      if (phase_tag != "") e0_tag = phase_tag;
      else if (tie && k == 0) e0_tag = "R6";
      else if (k == 2) e0_tag = "R5";
      else e0_tag = "R4";
    end else begin
      e0_v = 0; e0_f = 0; e0_p = 0;
      e0_vtag = (phase_tag == "R8") ? "R8" : "R3";
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    in_lo = $urandom; in_mid = $urandom; in_hi = $urandom;  // ignored data
    e0_v = 0; e0_f = 0; e0_p = 0;
    e0_vtag = (phase_tag == "R9") ? "R9" : "R2";
  endtask

  // send `npix` pixels of the frame in raster order; gaps inserts idle slots
  task automatic send(input int npix, input bit gaps);
    for (int i = 0; i < npix; i++) begin
      push(i % W, i / W, i == 0);
      if (gaps && ($urandom_range(2) == 0)) idle();
    end
  endtask

  task automatic fill_rand(input int lo, input int hi);
    for (int p = 0; p < 3; p++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++)
          fr[p][y][x] = lo + int'($urandom_range(hi - lo));
  endtask

  task automatic fill_const(input int v);
    for (int p = 0; p < 3; p++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++)
          fr[p][y][x] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "kp_valid in reset", int'(kp_valid), 0);
    chk("R1", "kp_flag in reset", int'(kp_flag), 0);
    chk("R1", "kp_pol in reset", int'(kp_pol), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "kp_valid after reset", int'(kp_valid), 0);
    chk_en = 1;

    // R4 R5 R6: dense ties and extrema from a narrow value range
    for (int f = 0; f < 3; f++) begin
      fill_rand(-2, 2);
      send(W*H, 0);
    end
    // R4 R5: wide range
    fill_rand(-60, 60);
    send(W*H, 0);

    // directed: peak, pit, tie, border peak
    fill_const(0);
    fr[1][2][2] = 40;                  // R4 maximum at (2,2)
    fr[1][3][5] = -40;                 // R5 minimum at (5,3)
    fr[1][2][4] = 30; fr[2][1][3] = 30; // R6 tie with upper plane
    fr[1][4][4] = -30; fr[0][5][5] = -30; // R6 tie with lower plane
    fr[1][0][0] = 99;                  // R3 border, never reported
    fr[1][3][7] = -99;                 // R3 right border
    send(W*H, 0);

    // R9: idle gaps with noise on the data pins
    phase_tag = "R9";
    for (int f = 0; f < 2; f++) begin
      fill_rand(-20, 20);
      send(W*H, 1);
    end

    // R10: signed extremes
    phase_tag = "R10";
    for (int f = 0; f < 2; f++) begin
      for (int p = 0; p < 3; p++)
        for (int y = 0; y < H; y++)
          for (int x = 0; x < W; x++) begin
            case ($urandom_range(3))
              0: fr[p][y][x] = -128;
              1: fr[p][y][x] = 127;
              2: fr[p][y][x] = -1;
              default: fr[p][y][x] = 0;
            endcase
          end
      fr[1][2][3] = 127;  fr[0][1][2] = -128;
      send(W*H, 0);
    end

    // R8: frame cut short mid-row, then a new frame
    phase_tag = "R8";
    fill_rand(-50, 50);
    send(3*W + 4, 0);
    fill_rand(-50, 50);
    send(W*H, 0);

    // R1: reset in the middle of a frame
    phase_tag = "";
    fill_rand(-10, 10);
    send(2*W + 5, 0);
    @(negedge clk);
    in_valid = 0; in_sof = 0; e0_v = 0; e0_f = 0; e0_p = 0;
    rst = 1;
    @(negedge clk);
    chk("R1", "kp_valid mid reset", int'(kp_valid), 0);
    chk("R1", "kp_flag mid reset", int'(kp_flag), 0);
    @(negedge clk);
    rst = 0;
    repeat (4) idle();
    fill_rand(-5, 5);
    send(W*H, 0);

    repeat (6) idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule